// File: doc/BRIEF.md
# CAN Receive Acceptance Filter and Message Object Scanner

This block takes one received frame per cycle: its identifier, extended-ID flag, remote flag, length code and payload. In the same cycle it compares that frame against a bank of message objects. Each object holds its own filter settings: a valid bit, an identifier, an optional per-bit acceptance mask, and separate mask enables for the extended-ID flag and the direction bit. The lowest-numbered object that accepts the frame is selected. If the frame is a data frame, its payload is stored there. If it is a remote frame and that object answers remote requests, its transmit request is raised instead.

Objects can be chained into a receive FIFO. A data frame skips any accepting object that still holds unread data, unless that object ends its chain. The last object of a chain is overwritten, and it records that a message was lost. A compact interrupt identifier reports a pending status event or the lowest-numbered object with a pending interrupt. A simple write port loads an object's settings and clears its flags. A read port returns an object's stored payload and length.

Top module: `can_accept_scan`

## Requirements
- R1: After reset, all per-object flags (new data, lost, interrupt pending, transmit request) are 0 and `int_id` is 0.
- R2: An object whose valid setting is 0 never accepts a frame and never changes its flags.
- R3: With the use-mask setting 0, an object accepts a frame only if all compared identifier bits, the extended flag and the direction match. The frame's direction is 1 for a remote frame and 0 for a data frame, and the object direction 1 means transmit.
- R4: With the use-mask setting 1, only identifier bits whose mask bit is 1 are compared. The extended flag is compared only when the mask-extended setting is 1, and the direction only when the mask-direction setting is 1.
- R5: For a standard frame (extended flag 0), only identifier bits 28..18 are compared. Bits 17..0 of both the frame and the object are ignored.
- R6: When several objects accept a frame, only the lowest-numbered one is updated.
- R7: A stored data frame writes its length code and payload and sets the new-data flag. It sets interrupt pending if the object's receive-interrupt enable is 1. Byte k sits at payload bits 8k+7..8k. Bytes at or beyond min(code, 8) are stored as 0, and `rd_len` is min(code, 8).
- R8: Storing a data frame into an object whose new-data flag is already 1 sets that object's lost flag. The lost flag is never set otherwise.
- R9: A remote frame sets the selected object's transmit request if its remote-enable setting is 1. It never changes new data, interrupt pending or stored payload.
- R10: For data frames, an accepting object with new data 1 and end-of-chain 0 is skipped. The next accepting object is tried. An end-of-chain object is always eligible.
- R11: `int_id` is 0x8000 while `status_irq` is 1. Otherwise it is n+1 for the lowest object n with interrupt pending, or 0 when none is pending.
- R12: A settings write to an object clears its four flags in the next cycle. Flags change only on a frame or a settings write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_valid | input | 1 | Frame present this cycle |
| frm_id | input | 29 | Frame identifier (standard ID in bits 28..18) |
| frm_xtd | input | 1 | Frame uses 29-bit identifier |
| frm_rtr | input | 1 | Frame is a remote request |
| frm_dlc | input | 4 | Frame length code |
| frm_data | input | 64 | Frame payload, byte 0 in bits 7..0 |
| cfg_we | input | 1 | Write settings of object `cfg_idx` |
| cfg_idx | input | 5 | Object number for settings write |
| cfg_val | input | 1 | Object valid |
| cfg_umask | input | 1 | Use acceptance mask |
| cfg_id | input | 29 | Object identifier |
| cfg_msk | input | 29 | Identifier mask |
| cfg_xtd | input | 1 | Object extended flag |
| cfg_mxtd | input | 1 | Compare extended flag under mask |
| cfg_dir | input | 1 | Object direction, 1 = transmit |
| cfg_mdir | input | 1 | Compare direction under mask |
| cfg_rxie | input | 1 | Receive interrupt enable |
| cfg_rmten | input | 1 | Remote frames raise transmit request |
| cfg_eob | input | 1 | Object ends its chain |
| status_irq | input | 1 | Status interrupt pending |
| rd_idx | input | 5 | Object to read |
| rd_data | output | 64 | Stored payload of `rd_idx` |
| rd_dlc | output | 4 | Stored length code of `rd_idx` |
| rd_len | output | 4 | Byte count of `rd_idx` |
| newdat_o | output | 32 | New-data flags |
| msglst_o | output | 32 | Lost flags |
| intpnd_o | output | 32 | Interrupt-pending flags |
| txrqst_o | output | 32 | Transmit-request flags |
| int_id | output | 16 | Interrupt identifier |

## Verification
The filter is driven with several kinds of identifier. Single-bit flips against an exact object show that every bit is compared. Differing low bits and a flipped top bit against a masked object show which bits the mask drops. Standard frames that differ only below bit 18 show that the short identifier is aligned. Frames that differ only in the extended flag or the remote flag, with and without the mask enables, show that those two bits are compared separately. Overlapping objects, a three-deep chain filled past its end, and repeated writes to one object show how the winner is chosen, when a frame goes to the next object in the chain, and when the lost flag is set.

// File: rtl/can_flt_pkg.sv
package can_flt_pkg;
  localparam int ID_W      = 29;
  localparam int STD_LSB   = 18;
  localparam int MAX_BYTES = 8;
  localparam int DATA_W    = MAX_BYTES * 8;
  localparam int DLC_W     = 4;
  localparam int INT_W     = 16;
  localparam logic [INT_W-1:0] STATUS_CODE = 16'h8000;

  typedef struct packed {
    logic            val;
    logic            umask;
    logic [ID_W-1:0] id;
    logic [ID_W-1:0] msk;
    logic            xtd;
    logic            mxtd;
    logic            dir;
    logic            mdir;
    logic            rxie;
    logic            rmten;
    logic            eob;
  } obj_cfg_t;

  // Byte count carried by a length code (codes above 8 mean 8).
  function automatic logic [DLC_W-1:0] dlc_len(input logic [DLC_W-1:0] dlc);
    return (dlc > DLC_W'(MAX_BYTES)) ? DLC_W'(MAX_BYTES) : dlc;
  endfunction

  // Zero every byte at or beyond the byte count.
  function automatic logic [DATA_W-1:0] keep_bytes(input logic [DATA_W-1:0] d,
                                                   input logic [DLC_W-1:0]  n);
    logic [DATA_W-1:0] r;
    r = '0;
    for (int b = 0; b < MAX_BYTES; b++)
      if (b < int'(n)) r[b*8 +: 8] = d[b*8 +: 8];
    return r;
  endfunction

  // Acceptance test of one object against one frame.
  function automatic logic obj_match(input obj_cfg_t        c,
                                     input logic [ID_W-1:0] fid,
                                     input logic            fxtd,
                                     input logic            frtr);
    logic [ID_W-1:0] cmp;
    logic id_ok, xtd_ok, dir_ok;
    cmp = c.umask ? c.msk : '1;
    if (!fxtd) cmp[STD_LSB-1:0] = '0;
    id_ok  = ((fid ^ c.id) & cmp) == '0;
    xtd_ok = (c.umask && !c.mxtd) || (fxtd == c.xtd);
    dir_ok = (c.umask && !c.mdir) || (frtr == c.dir);
    return c.val && id_ok && xtd_ok && dir_ok;
  endfunction
endpackage

// File: rtl/can_obj_match.sv
module can_obj_match
  import can_flt_pkg::*;
#(
  parameter int N = 32
) (
  input  obj_cfg_t        cfg_q [N],
  input  logic [ID_W-1:0] fid,
  input  logic            fxtd,
  input  logic            frtr,
  output logic [N-1:0]    hit,
  output logic [N-1:0]    eob
);
  for (genvar g = 0; g < N; g++) begin : g_obj
    assign hit[g] = obj_match(cfg_q[g], fid, fxtd, frtr);
    assign eob[g] = cfg_q[g].eob;
  end
endmodule

// File: rtl/can_lowest_pick.sv
module can_lowest_pick #(
  parameter int N  = 32,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (req[i]) idx = IW'(i);
  end
  assign found = |req;
endmodule

// File: rtl/can_int_id.sv
module can_int_id
  import can_flt_pkg::*;
#(
  parameter int N  = 32,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic             status,
  input  logic [N-1:0]     pend,
  output logic [INT_W-1:0] id
);
  logic          any;
  logic [IW-1:0] first;

  can_lowest_pick #(.N(N), .IW(IW)) u_pick (.req(pend), .found(any), .idx(first));

  always_comb begin
    if (status)   id = STATUS_CODE;
    else if (any) id = INT_W'(first) + INT_W'(1);
    else          id = '0;
  end
endmodule

// File: rtl/can_accept_scan.sv
module can_accept_scan
  import can_flt_pkg::*;
#(
  parameter int NUM_OBJ = 32,
  localparam int IDX_W  = (NUM_OBJ > 1) ? $clog2(NUM_OBJ) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frm_valid,
  input  logic [ID_W-1:0]    frm_id,
  input  logic               frm_xtd,
  input  logic               frm_rtr,
  input  logic [DLC_W-1:0]   frm_dlc,
  input  logic [DATA_W-1:0]  frm_data,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic               cfg_val,
  input  logic               cfg_umask,
  input  logic [ID_W-1:0]    cfg_id,
  input  logic [ID_W-1:0]    cfg_msk,
  input  logic               cfg_xtd,
  input  logic               cfg_mxtd,
  input  logic               cfg_dir,
  input  logic               cfg_mdir,
  input  logic               cfg_rxie,
  input  logic               cfg_rmten,
  input  logic               cfg_eob,
  input  logic               status_irq,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [DATA_W-1:0]  rd_data,
  output logic [DLC_W-1:0]   rd_dlc,
  output logic [DLC_W-1:0]   rd_len,
  output logic [NUM_OBJ-1:0] newdat_o,
  output logic [NUM_OBJ-1:0] msglst_o,
  output logic [NUM_OBJ-1:0] intpnd_o,
  output logic [NUM_OBJ-1:0] txrqst_o,
  output logic [INT_W-1:0]   int_id
);
  obj_cfg_t           cfg_q  [NUM_OBJ];
  logic [DATA_W-1:0]  data_q [NUM_OBJ];
  logic [DLC_W-1:0]   dlc_q  [NUM_OBJ];
  logic [NUM_OBJ-1:0] newdat, msglst, intpnd, txrqst;

  // Scan events, named for the checker.
  logic [NUM_OBJ-1:0] obj_hit, obj_eob, obj_cand;
  logic               scan_hit;
  logic [IDX_W-1:0]   scan_win;
  logic               store_ev, remote_ev, lose_ev;
  obj_cfg_t           cfg_new;

  can_obj_match #(.N(NUM_OBJ)) u_match (
    .cfg_q(cfg_q), .fid(frm_id), .fxtd(frm_xtd), .frtr(frm_rtr),
    .hit(obj_hit), .eob(obj_eob)
  );

  // Data frames pass over unread objects that do not end a chain.
  assign obj_cand = frm_rtr ? obj_hit : (obj_hit & (~newdat | obj_eob));

  can_lowest_pick #(.N(NUM_OBJ), .IW(IDX_W)) u_win (
    .req(obj_cand), .found(scan_hit), .idx(scan_win)
  );

  assign store_ev  = frm_valid && scan_hit && !frm_rtr;
  assign remote_ev = frm_valid && scan_hit && frm_rtr;
  assign lose_ev   = store_ev && newdat[scan_win];

  always_comb begin
    cfg_new       = '0;
    cfg_new.val   = cfg_val;
    cfg_new.umask = cfg_umask;
    cfg_new.id    = cfg_id;
    cfg_new.msk   = cfg_msk;
    cfg_new.xtd   = cfg_xtd;
    cfg_new.mxtd  = cfg_mxtd;
    cfg_new.dir   = cfg_dir;
    cfg_new.mdir  = cfg_mdir;
    cfg_new.rxie  = cfg_rxie;
    cfg_new.rmten = cfg_rmten;
    cfg_new.eob   = cfg_eob;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_OBJ; i++) begin
        cfg_q[i]  <= '0;
        data_q[i] <= '0;
        dlc_q[i]  <= '0;
      end
      newdat <= '0;
      msglst <= '0;
      intpnd <= '0;
      txrqst <= '0;
    end else begin
      if (store_ev) begin
        data_q[scan_win] <= keep_bytes(frm_data, dlc_len(frm_dlc));
        dlc_q[scan_win]  <= frm_dlc;
        newdat[scan_win] <= 1'b1;
        if (lose_ev)               msglst[scan_win] <= 1'b1;
        if (cfg_q[scan_win].rxie)  intpnd[scan_win] <= 1'b1;
      end
      if (remote_ev && cfg_q[scan_win].rmten) txrqst[scan_win] <= 1'b1;
      if (cfg_we) begin
        cfg_q[cfg_idx]  <= cfg_new;
        newdat[cfg_idx] <= 1'b0;
        msglst[cfg_idx] <= 1'b0;
        intpnd[cfg_idx] <= 1'b0;
        txrqst[cfg_idx] <= 1'b0;
      end
    end
  end

  can_int_id #(.N(NUM_OBJ), .IW(IDX_W)) u_irq (
    .status(status_irq), .pend(intpnd), .id(int_id)
  );

  assign rd_data  = data_q[rd_idx];
  assign rd_dlc   = dlc_q[rd_idx];
  assign rd_len   = dlc_len(dlc_q[rd_idx]);
  assign newdat_o = newdat;
  assign msglst_o = msglst;
  assign intpnd_o = intpnd;
  assign txrqst_o = txrqst;
endmodule

// File: rtl/can_accept_scan_chk.sv
module can_accept_scan_chk #(
  parameter int N  = 32,
  parameter int IW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frm_valid,
  input logic          frm_rtr,
  input logic          cfg_we,
  input logic          status_irq,
  input logic          store_ev,
  input logic [IW-1:0] scan_win,
  input logic [N-1:0]  newdat,
  input logic [N-1:0]  msglst,
  input logic [N-1:0]  intpnd,
  input logic [N-1:0]  txrqst,
  input logic [15:0]   int_id
);
  logic [IW-1:0] win_q;
  always_ff @(posedge clk) win_q <= scan_win;

  function automatic logic id_consistent(input logic [N-1:0] p, input logic [15:0] v);
    if (p == '0) return v == 16'd0;
    if (v == 16'd0 || int'(v) > N) return 1'b0;
    if (!p[int'(v) - 1]) return 1'b0;
    for (int i = 0; i < N; i++)
      if (i < int'(v) - 1 && p[i]) return 1'b0;
    return 1'b1;
  endfunction

  AST_STORE_SETS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    store_ev && !cfg_we |=> newdat[win_q]); // R7

  AST_LOST_NEEDS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ((msglst & ~$past(msglst) & ~$past(newdat)) == '0)); // R8

  AST_REMOTE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && frm_rtr && !cfg_we |=> $stable(newdat) && $stable(intpnd)); // R9

  AST_TXRQST_ONLY_REMOTE: assert property (@(posedge clk) disable iff (!rst_n)
    !(frm_valid && frm_rtr) && !cfg_we |=> $stable(txrqst)); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid && !cfg_we |=> $stable(newdat) && $stable(msglst) && $stable(intpnd)); // R12

  AST_INTID_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    status_irq |-> int_id == 16'h8000); // R11

  AST_INTID_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    !status_irq |-> id_consistent(intpnd, int_id)); // R11
endmodule

bind can_accept_scan can_accept_scan_chk #(.N(NUM_OBJ), .IW(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_rtr(frm_rtr),
  .cfg_we(cfg_we), .status_irq(status_irq), .store_ev(store_ev),
  .scan_win(scan_win), .newdat(newdat), .msglst(msglst), .intpnd(intpnd),
  .txrqst(txrqst), .int_id(int_id)
);

// File: tb/can_accept_scan_test.sv
module can_accept_scan_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        frm_valid, frm_xtd, frm_rtr;
  logic [28:0] frm_id;
  logic [3:0]  frm_dlc;
  logic [63:0] frm_data;
  logic        cfg_we, cfg_val, cfg_umask, cfg_xtd, cfg_mxtd, cfg_dir, cfg_mdir;
  logic        cfg_rxie, cfg_rmten, cfg_eob;
  logic [4:0]  cfg_idx, rd_idx;
  logic [28:0] cfg_id, cfg_msk;
  logic        status_irq;
  logic [63:0] rd_data;
  logic [3:0]  rd_dlc, rd_len;
  logic [31:0] newdat_o, msglst_o, intpnd_o, txrqst_o;
  logic [15:0] int_id;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  can_accept_scan uut (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_id(frm_id),
    .frm_xtd(frm_xtd), .frm_rtr(frm_rtr), .frm_dlc(frm_dlc), .frm_data(frm_data),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_val(cfg_val), .cfg_umask(cfg_umask),
    .cfg_id(cfg_id), .cfg_msk(cfg_msk), .cfg_xtd(cfg_xtd), .cfg_mxtd(cfg_mxtd),
    .cfg_dir(cfg_dir), .cfg_mdir(cfg_mdir), .cfg_rxie(cfg_rxie), .cfg_rmten(cfg_rmten),
    .cfg_eob(cfg_eob), .status_irq(status_irq), .rd_idx(rd_idx), .rd_data(rd_data),
    .rd_dlc(rd_dlc), .rd_len(rd_len), .newdat_o(newdat_o), .msglst_o(msglst_o),
    .intpnd_o(intpnd_o), .txrqst_o(txrqst_o), .int_id(int_id)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; frm_valid = 0; frm_xtd = 0; frm_rtr = 0; frm_id = '0;
    frm_dlc = '0; frm_data = '0; cfg_we = 0; cfg_idx = '0; cfg_val = 0;
    cfg_umask = 0; cfg_id = '0; cfg_msk = '0; cfg_xtd = 0; cfg_mxtd = 0;
    cfg_dir = 0; cfg_mdir = 0; cfg_rxie = 0; cfg_rmten = 0; cfg_eob = 0;
    status_irq = 0; rd_idx = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic set_obj(input int idx, input bit val, input bit umask,
                         input logic [28:0] id, input logic [28:0] msk,
                         input bit xtd, input bit mxtd, input bit dir, input bit mdir,
                         input bit rxie, input bit rmten, input bit eob);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 5'(idx); cfg_val = val; cfg_umask = umask; cfg_id = id;
    cfg_msk = msk; cfg_xtd = xtd; cfg_mxtd = mxtd; cfg_dir = dir; cfg_mdir = mdir;
    cfg_rxie = rxie; cfg_rmten = rmten; cfg_eob = eob;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic send(input logic [28:0] id, input bit xtd, input bit rtr,
                      input logic [3:0] dlc, input logic [63:0] data);
    @(negedge clk);
    frm_valid = 1; frm_id = id; frm_xtd = xtd; frm_rtr = rtr;
    frm_dlc = dlc; frm_data = data;
    @(negedge clk);
    frm_valid = 0;
  endtask

  localparam logic [28:0] ID_A = 29'h0ABC_DEF1;
  localparam logic [63:0] D1   = 64'hA1A2_A3A4_A5A6_A7A8;
  localparam logic [63:0] D2   = 64'hB1B2_B3B4_B5B6_B7B8;

  task automatic t_reset();
    do_reset();
    chk("R1 newdat", 64'(newdat_o), 0);
    chk("R1 flags", 64'(msglst_o | intpnd_o | txrqst_o), 0);
    chk("R1 int_id", 64'(int_id), 0);
  endtask

  task automatic t_exact();
    do_reset();
    set_obj(3, 1, 0, ID_A, '0, 1, 0, 0, 0, 1, 0, 1);
    send(ID_A ^ 29'h1, 1, 0, 8, D1);
    chk("R3 low bit differs", 64'(newdat_o), 0);
    send(ID_A, 0, 0, 8, D1);
    chk("R3 extended flag differs", 64'(newdat_o), 0);
    send(ID_A, 1, 1, 0, '0);
    chk("R3 direction differs", 64'(newdat_o | txrqst_o), 0);
    send(ID_A, 1, 0, 8, D1);
    chk("R3 exact accept", 64'(newdat_o), 64'(32'h8));
    rd_idx = 3; #1;
    chk("R7 payload", rd_data, D1);
    chk("R11 single pending", 64'(int_id), 4);
  endtask

  task automatic t_std();
    do_reset();
    set_obj(1, 1, 0, {11'h5A3, 18'h2AAAA}, '0, 0, 0, 0, 0, 0, 0, 1);
    send({11'h5A3, 18'h15555}, 0, 0, 2, D1);
    chk("R5 low bits ignored", 64'(newdat_o), 64'(32'h2));
    send({11'h5A2, 18'h2AAAA}, 0, 0, 2, D2);
    chk("R5 bit 18 compared", 64'(msglst_o), 0);
  endtask

  task automatic t_mask();
    do_reset();
    set_obj(2, 1, 1, 29'h1F00_0000, 29'h1FF0_0000, 1, 0, 0, 0, 1, 0, 1);
    send(29'h1F0A_BCDE, 0, 0, 1, D1);
    chk("R4 masked accept, extended not compared", 64'(newdat_o), 64'(32'h4));
    do_reset();
    set_obj(4, 1, 1, 29'h1F00_0000, 29'h1FF0_0000, 1, 1, 0, 0, 0, 1, 1);
    send(29'h1F0A_BCDE, 0, 0, 1, D1);
    chk("R4 extended compared", 64'(newdat_o), 0);
    send(29'h0F0A_BCDE, 1, 0, 1, D1);
    chk("R4 masked bit compared", 64'(newdat_o), 0);
    send(29'h1F0A_BCDE, 1, 0, 1, D1);
    chk("R4 masked accept", 64'(newdat_o), 64'(32'h10));
    send(29'h1F0A_BCDE, 1, 1, 0, '0);
    chk("R4 direction not compared", 64'(txrqst_o), 64'(32'h10));
  endtask

  task automatic t_prio();
    do_reset();
    set_obj(0, 0, 0, ID_A, '0, 1, 0, 0, 0, 0, 0, 1);
    set_obj(4, 1, 0, ID_A, '0, 1, 0, 0, 0, 0, 0, 1);
    set_obj(9, 1, 0, ID_A, '0, 1, 0, 0, 0, 0, 0, 1);
    send(ID_A, 1, 0, 8, D1);
    chk("R2 R6 invalid skipped, lowest wins", 64'(newdat_o), 64'(32'h10));
    set_obj(4, 0, 0, ID_A, '0, 1, 0, 0, 0, 0, 0, 1);
    chk("R12 write clears flags", 64'(newdat_o), 0);
    send(ID_A, 1, 0, 8, D1);
    chk("R2 invalidated object ignored", 64'(newdat_o), 64'(32'h200));
  endtask

  task automatic t_store();
    do_reset();
    set_obj(6, 1, 0, ID_A, '0, 1, 0, 0, 0, 0, 0, 1);
    send(ID_A, 1, 0, 3, 64'h1122_3344_5566_7788);
    rd_idx = 6; #1;
    chk("R7 short payload", rd_data, 64'h0000_0000_0066_7788);
    chk("R7 length", 64'(rd_len), 3);
    chk("R7 no interrupt without enable", 64'(intpnd_o), 0);
    send(ID_A, 1, 0, 13, D2);
    #1;
    chk("R7 long code payload", rd_data, D2);
    chk("R7 long code length", 64'(rd_len), 8);
    chk("R7 code kept", 64'(rd_dlc), 13);
    send(ID_A, 1, 0, 0, D2);
    #1;
    chk("R7 empty payload", rd_data, 0);
  endtask

  task automatic t_lost();
    do_reset();
    set_obj(7, 1, 0, ID_A, '0, 1, 0, 0, 0, 1, 0, 1);
    send(ID_A, 1, 0, 8, D1);
    chk("R8 first store not lost", 64'(msglst_o), 0);
    send(ID_A, 1, 0, 8, D2);
    rd_idx = 7; #1;
    chk("R8 overwrite lost", 64'(msglst_o), 64'(32'h80));
    chk("R8 overwrite payload", rd_data, D2);
  endtask

  task automatic t_remote();
    do_reset();
    set_obj(6, 1, 0, ID_A, '0, 1, 0, 1, 0, 1, 1, 1);
    set_obj(8, 1, 0, 29'h0000_1234, '0, 1, 0, 1, 0, 1, 0, 1);
    send(ID_A, 1, 1, 4, D1);
    chk("R9 remote raises request", 64'(txrqst_o), 64'(32'h40));
    chk("R9 remote stores nothing", 64'(newdat_o | intpnd_o), 0);
    send(29'h0000_1234, 1, 1, 4, D1);
    chk("R9 remote disabled", 64'(txrqst_o), 64'(32'h40));
  endtask

  task automatic t_fifo();
    do_reset();
    set_obj(10, 1, 0, ID_A, '0, 1, 0, 0, 0, 1, 0, 0);
    set_obj(11, 1, 0, ID_A, '0, 1, 0, 0, 0, 1, 0, 0);
    set_obj(12, 1, 0, ID_A, '0, 1, 0, 0, 0, 1, 0, 1);
    send(ID_A, 1, 0, 8, 64'h1);
    chk("R10 chain head", 64'(newdat_o), 64'(32'h400));
    send(ID_A, 1, 0, 8, 64'h2);
    chk("R10 chain second", 64'(newdat_o), 64'(32'hC00));
    send(ID_A, 1, 0, 8, 64'h3);
    chk("R10 chain end", 64'(newdat_o), 64'(32'h1C00));
    send(ID_A, 1, 0, 8, 64'h4);
    chk("R10 end overwritten", 64'(msglst_o), 64'(32'h1000));
    rd_idx = 12; #1;
    chk("R10 end payload", rd_data, 64'h4);
    rd_idx = 10; #1;
    chk("R10 head kept", rd_data, 64'h1);
  endtask

  task automatic t_irq();
    do_reset();
    set_obj(3, 1, 0, 29'h0000_0333, '0, 1, 0, 0, 0, 1, 0, 1);
    set_obj(8, 1, 0, 29'h0000_0888, '0, 1, 0, 0, 0, 1, 0, 1);
    send(29'h0000_0888, 1, 0, 1, D1);
    chk("R11 object 8", 64'(int_id), 9);
    send(29'h0000_0333, 1, 0, 1, D1);
    chk("R11 lowest reported", 64'(int_id), 4);
    status_irq = 1; #1;
    chk("R11 status first", 64'(int_id), 64'h8000);
    status_irq = 0; #1;
    chk("R11 status released", 64'(int_id), 4);
    set_obj(3, 1, 0, 29'h0000_0333, '0, 1, 0, 0, 0, 1, 0, 1);
    chk("R12 pending cleared", 64'(intpnd_o), 64'(32'h100));
    chk("R11 next source", 64'(int_id), 9);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_exact();
    t_std();
    t_mask();
    t_prio();
    t_store();
    t_lost();
    t_remote();
    t_fifo();
    t_irq();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule